// File: doc/BRIEF.md
# Watchdog Timer With Deferred Enable

This block is a watchdog timer clocked by the state-time clock. Once it is running, software has to issue a clear strobe at least once every 2^CNT_W state times. With the default width that is 65536 state times. If no clear arrives in time, the block issues a one-clock reset request to the system reset generator. The key sequence that software uses to produce the clear strobe is outside this block.

A configuration bit is captured while reset is held and selects the start-up behaviour:

- **Bit low:** the watchdog runs as soon as reset is released.
- **Bit high:** the watchdog stays dormant. Its counter is held at zero and it can never request a reset. The first clear strobe starts it.

Once the watchdog is running, only a reset stops it. An `armed` output shows whether the watchdog is running.

Top module: `wdog_deferred`

## Requirements
- R1: When `defer_cfg` is 0 during reset, `armed` is 1 in the first cycle after reset and counting starts without any clear.
- R2: When `defer_cfg` is 1 during reset, `armed` stays 0 and `rst_req` stays 0 for as long as no clear strobe arrives.
- R3: A clear strobe (`kick` high at a clock edge) sets `armed` from that edge onward.
- R4: With `armed` set and no `kick`, `rst_req` rises at the 2^CNT_W-th clock edge after the last edge with `kick` high, or after reset release when none has occurred.
- R5: `rst_req` is high for exactly one cycle. The count then restarts from zero, so without clears the pulses repeat every 2^CNT_W cycles.
- R6: A `kick` at any edge restarts the timeout window, including at the edge where the timeout would otherwise occur; no `rst_req` follows that edge.
- R7: Once `armed` is 1 it stays 1 until reset. `defer_cfg` changes after reset release have no effect on `armed` or on the timing of `rst_req`.
- R8: While `rst_n` is low, `rst_req` is 0 and `armed` equals the inverse of `defer_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | State-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| defer_cfg | input | 1 | Start-up option captured during reset: 1 = dormant until first clear |
| kick | input | 1 | Clear strobe, one cycle per clear |
| rst_req | output | 1 | One-cycle reset request on timeout |
| armed | output | 1 | Watchdog is running |

## Verification
The hardest case to reach is the timeout itself at full width: it needs 65536 quiet cycles after the last clear. It also needs a clear landing exactly on the edge where the timeout would fire.

The bench runs a narrow instance (5-bit count) and a full-width instance side by side on the same stimulus. On the narrow instance, it sweeps the clear spacing through every value around the 32-cycle window, including the colliding edge. It then lets the full-width instance run past one complete 65536-cycle window, so the real timeout and its single-cycle pulse are seen at the ports.

// File: rtl/wdog_deferred.sv
module wdog_deferred #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic defer_cfg,
  input  logic kick,
  output logic rst_req,
  output logic armed
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             expire;

  assign expire = armed && !kick && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    armed <= !defer_cfg;
    else if (kick) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kick || !armed || expire) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire;
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_stay_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_dormant_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!rst_req && cnt == '0));

  assert_kick_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (armed && !rst_req));

  assert_kick_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));

endmodule

// File: tb/tb_wdog_deferred.sv
module tb_wdog_deferred;
  localparam int SW = 5;
  localparam int LIM_S = 1 << SW;
  localparam int LIM_F = 1 << 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic defer_cfg = 1'b0;
  logic kick = 1'b0;
  logic req_s, arm_s, req_f, arm_f;

  int checks = 0;
  int fails = 0;
  string tag = "R8";
  bit seen_edge = 1'b0;

  int  ms_n, mf_n;
  bit  ms_arm, mf_arm, ms_req, mf_req;

  always #2.5 clk = ~clk;

  wdog_deferred #(.CNT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .defer_cfg(defer_cfg), .kick(kick),
    .rst_req(req_s), .armed(arm_s));

  wdog_deferred dut_full (
    .clk(clk), .rst_n(rst_n), .defer_cfg(defer_cfg), .kick(kick),
    .rst_req(req_f), .armed(arm_f));

  always @(posedge clk) begin
    seen_edge <= 1'b1;
    if (!rst_n) begin
      ms_arm <= !defer_cfg; mf_arm <= !defer_cfg;
      ms_n <= 0; mf_n <= 0; ms_req <= 0; mf_req <= 0;
    end else begin
      if (kick) begin
        ms_arm <= 1; ms_n <= 0; ms_req <= 0;
      end else if (ms_arm) begin
        if (ms_n + 1 == LIM_S) begin ms_n <= 0; ms_req <= 1; end
        else begin ms_n <= ms_n + 1; ms_req <= 0; end
      end else ms_req <= 0;
      if (kick) begin
        mf_arm <= 1; mf_n <= 0; mf_req <= 0;
      end else if (mf_arm) begin
        if (mf_n + 1 == LIM_F) begin mf_n <= 0; mf_req <= 1; end
        else begin mf_n <= mf_n + 1; mf_req <= 0; end
      end else mf_req <= 0;
    end
  end

  always @(negedge clk) begin
    if (seen_edge) begin
      checks++;
      if (req_s !== ms_req || arm_s !== ms_arm) begin
        fails++;
        $display("FAIL %s narrow: rst_req=%0b armed=%0b expected rst_req=%0b armed=%0b",
                 tag, req_s, arm_s, ms_req, ms_arm);
      end
      checks++;
      if (req_f !== mf_req || arm_f !== mf_arm) begin
        fails++;
        $display("FAIL %s full: rst_req=%0b armed=%0b expected rst_req=%0b armed=%0b",
                 tag, req_f, arm_f, mf_req, mf_arm);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_kick();
    kick = 1'b1; cyc(1); kick = 1'b0;
  endtask

  task automatic do_reset(input bit d);
    tag = "R8"; rst_n = 1'b0; defer_cfg = d; cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // R1 / R4 / R5: running from reset, repeated timeouts on narrow instance
    do_reset(1'b0);
    tag = "R1"; cyc(2);
    tag = "R4"; cyc(LIM_S);
    tag = "R5"; cyc(2 * LIM_S + 3);
    // R7: configuration changes after reset ignored
    tag = "R7"; defer_cfg = 1'b1; cyc(LIM_S + 4); defer_cfg = 1'b0;
    // R6: sweep clear spacing across the window, including the colliding edge
    tag = "R6";
    for (int g = 1; g <= LIM_S + 2; g++) begin
      do_kick(); cyc(g - 1);
    end
    do_kick(); cyc(LIM_S - 1); do_kick(); cyc(LIM_S + 2);
    // R2 / R3: dormant start, then armed by first clear
    do_reset(1'b1);
    tag = "R2"; cyc(3 * LIM_S);
    tag = "R3"; do_kick(); cyc(2);
    tag = "R4"; cyc(LIM_S + 2);
    tag = "R7"; defer_cfg = 1'b0; cyc(LIM_S);
    // full width: one complete window from reset
    do_reset(1'b0);
    tag = "R4"; cyc(LIM_F + 10);
    tag = "R5"; cyc(20);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule